// File: doc/BRIEF.md
# Low-Side Channel Fault Guard and Status Encoder

This block watches eight low-side output channels. For each channel it receives the commanded state, a comparator flag that is high when the output voltage sits above the diagnostic threshold, and an overcurrent flag. The first two channels also receive an overtemperature flag. Each channel's drive enable is gated by a small per-channel state machine. On the six general channels, an overcurrent that lasts a set number of cycles trips the channel off. On the two inrush-tolerant channels, the same condition first moves the channel into current regulation, and only an overtemperature during regulation trips it.

Each channel's state machine has three states. CH_RUN is normal operation, and an overcurrent counter runs while the channel is commanded on. CH_LIMIT means current regulation, and only the first two channels can enter it. CH_TRIP means latched off. The transitions are:
- run-to-limit: the overcurrent persists for the diagnostic filter time on a regulating channel.
- run-to-trip: the overcurrent persists for the short-circuit delay on a general channel.
- limit-to-trip: overtemperature while in regulation.
- limit-to-run: the overcurrent clears, or the command goes off.
- trip-to-run: the command goes off.

A sticky fault latch per channel feeds an 8-bit status word. The latch is reloaded with the present fault condition on each falling edge of the chip-select line. The comparator flags of the first two channels are debounced before use. The status encoding depends on whether those two channels are under direct-pin control or serial control.

Top module: `lsd_fault_monitor`

## Requirements
- R1: While reset is asserted, no channel is in CH_TRIP or CH_LIMIT, `cur_reg` is 0 and every fault latch is 0.
- R2: On channels 3 to 8 (index 2 to 7), an overcurrent held for SC_DLY consecutive cycles while commanded on drops `drive_en` on the next cycle. An overcurrent held for SC_DLY-1 cycles leaves the channel enabled.
- R3: On channels 1 and 2 (index 0 and 1), an overcurrent held for DF_DLY consecutive cycles sets `cur_reg` and keeps `drive_en` high. An overcurrent held for DF_DLY-1 cycles does not set `cur_reg`.
- R4: A channel in regulation that sees `over_temp` trips off on the next cycle. `over_temp` has no effect on a channel that is not in regulation.
- R5: Regulation ends one cycle after the overcurrent goes away, and the channel stays enabled.
- R6: A tripped channel stays off while commanded on. It is re-enabled once its command has gone low for at least one cycle and then high again.
- R7: In serial encoding, the status bit is high for off-and-above (normal), low for off-and-below (fault), low for on-and-below (normal) and high for on-and-above (fault).
- R8: When `direct_mode[i]` is 1 for channel index 0 or 1, that channel's status bit is high for no fault and low for any fault, whatever the command.
- R9: On channels index 0 and 1, the comparator flag must differ from its debounced value for DF_DLY consecutive cycles before it changes the fault condition. Shorter excursions have no effect.
- R10: Fault latches are sticky. A `cs_n` falling edge replaces each latch with the present fault condition, so a fault that has since cleared then reads as no fault.
- R11: A tripped channel that is still commanded on counts as faulted, so in serial encoding its status bit reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select; its falling edge reloads the fault latches |
| direct_mode | input | NREG | Per regulating channel: 1 selects the direct-pin status encoding |
| cmd_on | input | NCH | Commanded on state per channel |
| above_thr | input | NCH | Output voltage above the diagnostic threshold |
| over_cur | input | NCH | Overcurrent flag per channel |
| over_temp | input | NREG | Overtemperature flag for the regulating channels |
| drive_en | output | NCH | Gated gate-drive enable per channel |
| cur_reg | output | NREG | Regulating channel is in current regulation |
| status | output | NCH | Encoded diagnostic status word |

## Verification
The bench drives overcurrent pulses exactly one cycle shorter and exactly as long as each filter window. A counter that is off by one would trip, or enter regulation, one pulse too early or fail to do so at the exact length. It raises overtemperature on a channel outside regulation, where a design that trips on any overtemperature would wrongly cut the drive. It checks all four status combinations in serial encoding and the inverted on-state in direct mode. A swapped polarity shows up as flipped bits. It also dips a debounced comparator for one cycle less than the window, and holds a fault latch across a cleared condition until the next chip-select fall. A design that fails to latch would report the fault too briefly, and one that never reloads would report it forever.

// File: rtl/lsd_fault_pkg.sv
package lsd_fault_pkg;

    typedef enum logic [1:0] {
        CH_RUN   = 2'd0,
        CH_LIMIT = 2'd1,
        CH_TRIP  = 2'd2
    } ch_state_e;

    // Status encoding: direct mode reports "no fault" as high in every state;
    // serial mode inverts the sense while the channel is commanded on.
    function automatic logic encode_status(input logic direct,
                                           input logic cmd,
                                           input logic flt);
        logic b;
        if (direct)   b = ~flt;
        else if (cmd) b = flt;
        else          b = ~flt;
        return b;
    endfunction

endpackage

// File: rtl/lsd_ch_guard.sv
module lsd_ch_guard
    import lsd_fault_pkg::*;
#(
    parameter int   DLY          = 6,
    parameter logic CAN_REGULATE = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd,
    input  logic      oc,
    input  logic      ot,
    output logic      en,
    output ch_state_e state_o
);
    localparam int CW = $clog2(DLY + 1);

    ch_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            CH_RUN: begin
                if (cmd && oc) begin
                    if (cnt_q == CW'(DLY - 1))
                        state_d = CAN_REGULATE ? CH_LIMIT : CH_TRIP;
                    else
                        cnt_d = cnt_q + 1'b1;
                end
            end
            CH_LIMIT: begin
                if (!cmd)     state_d = CH_RUN;
                else if (ot)  state_d = CH_TRIP;
                else if (!oc) state_d = CH_RUN;
            end
            CH_TRIP: begin
                if (!cmd) state_d = CH_RUN;
            end
            default: state_d = CH_RUN;
        endcase
    end

    always_comb begin
        en      = cmd && (state_q != CH_TRIP);
        state_o = state_q;
    end

endmodule

// File: rtl/lsd_diag_filter.sv
module lsd_diag_filter #(
    parameter int DLY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(DLY + 1);

    logic          filt_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else if (raw != filt_q) begin
            if (cnt_q == CW'(DLY - 1)) begin
                filt_q <= raw;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign filt = filt_q;

endmodule

// File: rtl/lsd_fault_monitor.sv
module lsd_fault_monitor
    import lsd_fault_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int NREG   = 2,
    parameter int SC_DLY = 6,
    parameter int DF_DLY = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic [NREG-1:0] direct_mode,
    input  logic [NCH-1:0]  cmd_on,
    input  logic [NCH-1:0]  above_thr,
    input  logic [NCH-1:0]  over_cur,
    input  logic [NREG-1:0] over_temp,
    output logic [NCH-1:0]  drive_en,
    output logic [NREG-1:0] cur_reg,
    output logic [NCH-1:0]  status
);
    logic [NCH-1:0] tripped;
    logic [NCH-1:0] cmp_seen;
    logic [NCH-1:0] flt_now;
    logic [NCH-1:0] flt_q;
    logic           cs_q;
    logic           cs_fall;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ch_state_e st;
        if (i < NREG) begin : g_reg
            lsd_ch_guard #(.DLY(DF_DLY), .CAN_REGULATE(1'b1)) u_guard (
                .clk(clk), .rst_n(rst_n), .cmd(cmd_on[i]), .oc(over_cur[i]),
                .ot(over_temp[i]), .en(drive_en[i]), .state_o(st)
            );
            lsd_diag_filter #(.DLY(DF_DLY)) u_filt (
                .clk(clk), .rst_n(rst_n), .raw(above_thr[i]), .filt(cmp_seen[i])
            );
            assign cur_reg[i] = (st == CH_LIMIT);
            assign status[i]  = encode_status(direct_mode[i], cmd_on[i], flt_q[i]);
        end else begin : g_gen
            lsd_ch_guard #(.DLY(SC_DLY), .CAN_REGULATE(1'b0)) u_guard (
                .clk(clk), .rst_n(rst_n), .cmd(cmd_on[i]), .oc(over_cur[i]),
                .ot(1'b0), .en(drive_en[i]), .state_o(st)
            );
            assign cmp_seen[i] = above_thr[i];
            assign status[i]   = encode_status(1'b0, cmd_on[i], flt_q[i]);
        end
        assign tripped[i] = (st == CH_TRIP);
        assign flt_now[i] = tripped[i] | (cmd_on[i] ? cmp_seen[i] : ~cmp_seen[i]);
    end

    assign cs_fall = cs_q & ~cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            flt_q <= '0;
        end else begin
            cs_q  <= cs_n;
            flt_q <= cs_fall ? flt_now : (flt_q | flt_now);
        end
    end

endmodule

// File: rtl/lsd_fault_monitor_chk.sv
module lsd_fault_monitor_chk #(
    parameter int NCH  = 8,
    parameter int NREG = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCH-1:0]  cmd_on,
    input logic [NCH-1:0]  over_cur,
    input logic [NREG-1:0] over_temp,
    input logic [NCH-1:0]  drive_en,
    input logic [NREG-1:0] cur_reg
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R6: re-commanding a channel after an off cycle enables it
        a_r6_recommand_enables: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(!cmd_on[i]) && cmd_on[i]) |-> drive_en[i]);
        if (i < NREG) begin : g_reg
            // R3: regulation never removes the drive while commanded on
            a_r3_reg_keeps_drive: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_reg[i] && cmd_on[i]) |-> drive_en[i]);
            // R5: regulation is only entered while overcurrent is present
            a_r5_reg_needs_oc: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(cur_reg[i]) |-> $past(over_cur[i]));
            // R4: a regulating channel only trips from regulation plus overtemperature
            a_r4_trip_needs_ot: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(drive_en[i]) && cmd_on[i] && $past(cmd_on[i]))
                    |-> $past(cur_reg[i] && over_temp[i]));
        end else begin : g_gen
            // R2: a general channel only trips after overcurrent
            a_r2_trip_needs_oc: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(drive_en[i]) && cmd_on[i] && $past(cmd_on[i]))
                    |-> $past(over_cur[i]));
        end
    end
endmodule

bind lsd_fault_monitor lsd_fault_monitor_chk #(.NCH(NCH), .NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .over_cur(over_cur),
    .over_temp(over_temp), .drive_en(drive_en), .cur_reg(cur_reg)
);

// File: tb/lsd_fault_monitor_tb.sv
module lsd_fault_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 8;
    localparam int NREG = 2;
    localparam int SC   = 6;
    localparam int DF   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic [NREG-1:0] dmode = '0;
    logic [NCH-1:0]  cmd = '0, abv = '0, oc = '0;
    logic [NREG-1:0] ot = '0;
    logic [NCH-1:0]  en, st;
    logic [NREG-1:0] cr;

    int n_chk = 0;
    int n_bad = 0;

    lsd_fault_monitor #(.NCH(NCH), .NREG(NREG), .SC_DLY(SC), .DF_DLY(DF)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .direct_mode(dmode),
        .cmd_on(cmd), .above_thr(abv), .over_cur(oc), .over_temp(ot),
        .drive_en(en), .cur_reg(cr), .status(st)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: 0 normal, 1 regulating, 2 latched off
    int m_mode [NCH];
    int m_run  [NCH];
    int m_drun [NREG];
    bit m_filt [NREG];
    bit m_flt  [NCH];
    bit m_csq = 1'b1;

    initial begin
        for (int i = 0; i < NCH; i++) begin m_mode[i] = 0; m_run[i] = 0; m_flt[i] = 0; end
        for (int i = 0; i < NREG; i++) begin m_drun[i] = 0; m_filt[i] = 0; end
    end

    function automatic bit seen(int i);
        return (i < NREG) ? m_filt[i] : abv[i];
    endfunction

    always @(posedge clk) begin
        bit fnow [NCH];
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin m_mode[i] = 0; m_run[i] = 0; m_flt[i] = 0; end
            for (int i = 0; i < NREG; i++) begin m_drun[i] = 0; m_filt[i] = 0; end
            m_csq = 1'b1;
        end else begin
            for (int i = 0; i < NCH; i++)
                fnow[i] = (m_mode[i] == 2) || (cmd[i] ? seen(i) : !seen(i));
            for (int i = 0; i < NCH; i++)
                m_flt[i] = (m_csq && !cs_n) ? fnow[i] : (m_flt[i] || fnow[i]);
            for (int i = 0; i < NCH; i++) begin
                bit hot;
                int lim;
                hot = (i < NREG) ? ot[i] : 1'b0;
                lim = (i < NREG) ? DF : SC;
                if (!cmd[i]) begin
                    m_mode[i] = 0; m_run[i] = 0;
                end else if (m_mode[i] == 2) begin
                    m_run[i] = 0;
                end else if (m_mode[i] == 1) begin
                    if (hot) m_mode[i] = 2;
                    else if (!oc[i]) m_mode[i] = 0;
                end else if (oc[i]) begin
                    m_run[i]++;
                    if (m_run[i] >= lim) begin
                        m_mode[i] = (i < NREG) ? 1 : 2;
                        m_run[i] = 0;
                    end
                end else begin
                    m_run[i] = 0;
                end
            end
            for (int i = 0; i < NREG; i++) begin
                if (abv[i] != m_filt[i]) begin
                    m_drun[i]++;
                    if (m_drun[i] >= DF) begin m_filt[i] = abv[i]; m_drun[i] = 0; end
                end else begin
                    m_drun[i] = 0;
                end
            end
            m_csq = cs_n;
        end
    end

    task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) begin
            logic [7:0] e_en, e_st;
            logic [1:0] e_cr;
            @(posedge clk);
            #2;
            for (int i = 0; i < NCH; i++) begin
                e_en[i] = cmd[i] && (m_mode[i] != 2);
                if (i < NREG && dmode[i]) e_st[i] = !m_flt[i];
                else e_st[i] = cmd[i] ? m_flt[i] : !m_flt[i];
            end
            for (int i = 0; i < NREG; i++) e_cr[i] = (m_mode[i] == 1);
            check(en == e_en, "model drive_en", en, e_en);
            check(cr == e_cr, "model cur_reg", {6'b0, cr}, {6'b0, e_cr});
            check(st == e_st, "model status", st, e_st);
        end
    endtask

    task automatic cs_pulse();
        cs_n = 1'b0; cyc(1);
        cs_n = 1'b1; cyc(1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        cyc(3);
        check(en == 8'h00, "R1 drive_en", en, 8'h00);
        check(cr == 2'b00, "R1 cur_reg", {6'b0, cr}, 8'h00);
        check(st == 8'hFF, "R1 status", st, 8'hFF);
        rst_n = 1'b1;
        cmd = 8'hFF;
        cyc(25);
        cs_pulse();
        check(st == 8'h00, "R7 on-below", st, 8'h00);

        // R2 pulses on index 2
        oc[2] = 1'b1; cyc(SC - 1); oc[2] = 1'b0; cyc(2);
        check(en[2] == 1'b1, "R2 short pulse", {7'b0, en[2]}, 8'h01);
        oc[2] = 1'b1; cyc(SC);
        check(en == 8'hFB, "R2 trip", en, 8'hFB);
        oc[2] = 1'b0; cyc(2);
        check(en[2] == 1'b0, "R6 held", {7'b0, en[2]}, 8'h00);
        cs_pulse();
        check(st == 8'h04, "R11 tripped status", st, 8'h04);
        cmd[2] = 1'b0; cyc(1); cmd[2] = 1'b1; cyc(1);
        check(en[2] == 1'b1, "R6 re-enable", {7'b0, en[2]}, 8'h01);

        // R3 regulation entry on index 0
        oc[0] = 1'b1; cyc(DF - 1);
        check(cr[0] == 1'b0, "R3 short", {7'b0, cr[0]}, 8'h00);
        cyc(1);
        check(cr == 2'b01 && en[0], "R3 regulate", {6'b0, cr}, 8'h01);

        // R4 overtemperature
        ot[1] = 1'b1; cyc(3);
        check(en[1] == 1'b1, "R4 ignored", {7'b0, en[1]}, 8'h01);
        ot[1] = 1'b0; ot[0] = 1'b1; cyc(1);
        check(en[0] == 1'b0 && cr[0] == 1'b0, "R4 trip", {6'b0, cr[0], en[0]}, 8'h00);
        ot[0] = 1'b0; oc[0] = 1'b0; cyc(3);
        check(en[0] == 1'b0, "R6 held reg ch", {7'b0, en[0]}, 8'h00);
        cmd[0] = 1'b0; cyc(1); cmd[0] = 1'b1; cyc(1);
        check(en[0] == 1'b1, "R6 re-enable reg ch", {7'b0, en[0]}, 8'h01);

        // R5 exit from regulation on index 1
        oc[1] = 1'b1; cyc(DF);
        check(cr[1] == 1'b1, "R5 entered", {7'b0, cr[1]}, 8'h01);
        oc[1] = 1'b0; cyc(1);
        check(cr[1] == 1'b0 && en[1], "R5 exit", {6'b0, cr[1], en[1]}, 8'h01);

        // R7 serial encodings on indices 4..7
        cmd = 8'b1100_1111; abv = 8'b1001_0000; cyc(2);
        cs_pulse();
        check(st[7:4] == 4'b1001, "R7 four cases", {4'b0, st[7:4]}, 8'h09);

        // R8 direct-pin inversion on indices 0 and 1
        dmode = 2'b11; abv[1] = 1'b1; cyc(DF + 2);
        cs_pulse();
        check(st[1:0] == 2'b01, "R8 direct", {6'b0, st[1:0]}, 8'h01);

        // R9 debounce on index 1 (off, above is normal)
        cmd[1] = 1'b0; cyc(2);
        cs_pulse();
        check(st[1] == 1'b1, "R9 baseline", {7'b0, st[1]}, 8'h01);
        abv[1] = 1'b0; cyc(DF - 1); abv[1] = 1'b1; cyc(2);
        check(st[1] == 1'b1, "R9 short dip", {7'b0, st[1]}, 8'h01);
        abv[1] = 1'b0; cyc(DF); abv[1] = 1'b1; cyc(1);
        check(st[1] == 1'b0, "R9 long dip", {7'b0, st[1]}, 8'h00);

        // R10 sticky then reload
        cyc(DF + 3);
        check(st[1] == 1'b0, "R10 sticky", {7'b0, st[1]}, 8'h00);
        cs_n = 1'b0; cyc(1);
        check(st[1] == 1'b1, "R10 reload", {7'b0, st[1]}, 8'h01);
        cs_n = 1'b1; cyc(2);

        finish_run();
    end
endmodule